// File: doc/BRIEF.md
# Arithmetic Shift Unit with Condition Flags

This block performs an arithmetic shift, left or right, on an 8-bit, 16-bit or 32-bit operand and produces the carry, zero, overflow and negative flags for the shifted value. The operand size comes from a two-bit size code, which matches bits 11:10 of the instruction word. A 32-bit operand is built from a register pair. The destination register's 16-bit value forms the low half and the next register's value forms the high half. The 32-bit result comes back split the same way.

The shift count has two possible sources. A register-supplied count keeps only its low five bits. An immediate count keeps four bits for byte and word shifts and five bits for doubleword shifts. A one-cycle start strobe launches an operation. The result, the flags, `done_o` and `illegal_o` are registered and appear on the clock edge that samples the strobe. The flags are rebuilt from scratch for every shift, so no earlier flag value leaks into a legal result. The reserved size code is refused: it returns the operand unchanged, keeps the previous flags, and raises `illegal_o`.

Top module: `ashift_unit`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it, all outputs are 0.
- R2: The size code selects the operand width: 0 is byte (`opnd_lo_i[7:0]`), 1 is word (`opnd_lo_i`), and 3 is doubleword (`{opnd_hi_i, opnd_lo_i}`). For byte size, `res_lo_o[15:8]` passes `opnd_lo_i[15:8]` through unchanged. For byte and word sizes, `res_hi_o` passes `opnd_hi_i` through unchanged.
- R3: When `cnt_from_reg_i` is 1, the count is `reg_cnt_i[4:0]` and all higher bits are ignored. When it is 0, the count is `imm_cnt_i[3:0]` for byte and word sizes and `imm_cnt_i[4:0]` for doubleword size.
- R4: With `dir_right_i` = 0, the result is the operand shifted left by the count at the selected width, with zeros entering at the low end. A count equal to or above the width gives 0.
- R5: With `dir_right_i` = 1, the result is the operand shifted right by the count, with the operand's original sign bit filling the vacated high bits.
- R6: Carry is the last bit shifted out at the selected width. For a left shift with count n ≤ width, it is operand bit (width−n); for n above the width it is 0. For a right shift with n ≤ width, it is operand bit (n−1); for n above the width it is the sign bit. A count of 0 gives carry 0.
- R7: The zero flag is 1 exactly when the size-truncated result is all zeros.
- R8: For a left shift, overflow is 1 if the sign bit changes at any single step of the shift. For a right shift, overflow is 0.
- R9: The negative flag equals the result's most significant bit at the selected width.
- R10: Size code 2 is reserved. It returns both operand halves unchanged on the result outputs, holds all four flags at their previous values, and sets `illegal_o` to 1 together with `done_o`. `illegal_o` is 0 for legal sizes.
- R11: `done_o` is 1 exactly in the cycle after a cycle with `start_i` high. With no start, the result and flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch one shift in this cycle |
| size_i | input | 2 | Operand size code (0 byte, 1 word, 2 reserved, 3 doubleword) |
| dir_right_i | input | 1 | 1 selects a right shift, 0 a left shift |
| cnt_from_reg_i | input | 1 | 1 takes the count from `reg_cnt_i`, 0 from `imm_cnt_i` |
| reg_cnt_i | input | WORD_W | Register value that supplies the count |
| imm_cnt_i | input | CNT_W | Immediate count field |
| opnd_lo_i | input | WORD_W | Destination register value (low half) |
| opnd_hi_i | input | WORD_W | Next register value (high half for doubleword) |
| res_lo_o | output | WORD_W | Result, low half |
| res_hi_o | output | WORD_W | Result, high half |
| flag_c_o | output | 1 | Carry flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_n_o | output | 1 | Negative flag |
| done_o | output | 1 | Result valid |
| illegal_o | output | 1 | Reserved size code was used |

## Verification
Every result, flag, `done_o` and `illegal_o` is due on the first rising edge after the cycle in which `start_i` was high. The bench drives each operation on a falling edge and reads all outputs on the next falling edge, half a period after the edge that captured them. Expected values come from a bit-by-bit shift model that applies the requirement rules one step at a time. To test holding, the bench idles for one cycle and then rereads the outputs. For the reserved size code, it compares the flags with the values left by the operation before.

// File: rtl/ashift_pkg.sv
package ashift_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_RSVD  = 2'd2,
    SZ_DWORD = 2'd3
  } size_e;

  localparam int NUM_SIZES = 3;
endpackage

// File: rtl/ashift_cnt_sel.sv
module ashift_cnt_sel #(
  parameter int CNT_W = 5
) (
  input  logic             from_reg,
  input  logic             long_size,
  input  logic [CNT_W-1:0] reg_cnt,
  input  logic [CNT_W-1:0] imm_cnt,
  output logic [CNT_W-1:0] cnt
);
  // Short sizes take one bit less of immediate count.
  always_comb begin
    if (from_reg)       cnt = reg_cnt;
    else if (long_size) cnt = imm_cnt;
    else                cnt = {1'b0, imm_cnt[CNT_W-2:0]};
  end
endmodule

// File: rtl/ashift_core.sv
module ashift_core #(
  parameter int W     = 8,
  parameter int OUT_W = 32,
  parameter int CNT_W = 5
) (
  input  logic [W-1:0]     op,
  input  logic [CNT_W-1:0] cnt,
  input  logic             right,
  output logic [OUT_W-1:0] res,
  output logic             carry,
  output logic             ovf
);
  localparam int MAXC = (1 << CNT_W) - 1;
  localparam int EXT  = W + MAXC;

  logic [EXT-1:0] lwide;
  logic [EXT-1:0] rwide;
  logic [EXT-1:0] seq;
  logic [W-1:0]   sized;

  // The operand is widened so that every shifted-out bit stays visible.
  assign lwide = {{MAXC{1'b0}}, op} << cnt;
  assign rwide = EXT'($signed({op, {MAXC{1'b0}}}) >>> cnt);
  // seq holds the successive sign bits a step-by-step left shift would see.
  assign seq   = {op, {MAXC{1'b0}}};

  always_comb begin
    if (right) begin
      sized = rwide[EXT-1:MAXC];
      carry = rwide[MAXC-1];
    end else begin
      sized = lwide[W-1:0];
      carry = lwide[W];
    end
    res = '0;
    res[W-1:0] = sized;
  end

  always_comb begin
    ovf = 1'b0;
    for (int j = 1; j <= MAXC; j++) begin
      if (!right && (j <= int'(cnt)) && (seq[EXT-1-j] != op[W-1]))
        ovf = 1'b1;
    end
  end
endmodule

// File: rtl/ashift_unit.sv
module ashift_unit
  import ashift_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              dir_right_i,
  input  logic              cnt_from_reg_i,
  input  logic [WORD_W-1:0] reg_cnt_i,
  input  logic [CNT_W-1:0]  imm_cnt_i,
  input  logic [WORD_W-1:0] opnd_lo_i,
  input  logic [WORD_W-1:0] opnd_hi_i,
  output logic [WORD_W-1:0] res_lo_o,
  output logic [WORD_W-1:0] res_hi_o,
  output logic              flag_c_o,
  output logic              flag_z_o,
  output logic              flag_v_o,
  output logic              flag_n_o,
  output logic              done_o,
  output logic              illegal_o
);
  localparam int BYTE_W = WORD_W / 2;
  localparam int DW_W   = 2 * WORD_W;

  size_e           size;
  logic [CNT_W-1:0] cnt;
  logic [DW_W-1:0]  full_op;
  logic [DW_W-1:0]  sz_res [NUM_SIZES];
  logic             sz_c   [NUM_SIZES];
  logic             sz_v   [NUM_SIZES];

  logic [WORD_W-1:0] nxt_lo, nxt_hi;
  logic              nxt_c, nxt_z, nxt_v, nxt_n;

  assign size    = size_e'(size_i);
  assign full_op = {opnd_hi_i, opnd_lo_i};

  ashift_cnt_sel #(.CNT_W(CNT_W)) cnt_sel_i (
    .from_reg  (cnt_from_reg_i),
    .long_size (size == SZ_DWORD),
    .reg_cnt   (reg_cnt_i[CNT_W-1:0]),
    .imm_cnt   (imm_cnt_i),
    .cnt       (cnt)
  );

  // One shifter per width: byte, word, doubleword.
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    localparam int GW = BYTE_W << g;
    ashift_core #(.W(GW), .OUT_W(DW_W), .CNT_W(CNT_W)) core_i (
      .op    (full_op[GW-1:0]),
      .cnt   (cnt),
      .right (dir_right_i),
      .res   (sz_res[g]),
      .carry (sz_c[g]),
      .ovf   (sz_v[g])
    );
  end

  always_comb begin
    nxt_lo = opnd_lo_i;
    nxt_hi = opnd_hi_i;
    nxt_c  = 1'b0;
    nxt_v  = 1'b0;
    nxt_z  = 1'b0;
    nxt_n  = 1'b0;
    unique case (size)
      SZ_BYTE: begin
        nxt_lo = {opnd_lo_i[WORD_W-1:BYTE_W], sz_res[0][BYTE_W-1:0]};
        nxt_c  = sz_c[0];
        nxt_v  = sz_v[0];
        nxt_z  = (sz_res[0][BYTE_W-1:0] == '0);
        nxt_n  = sz_res[0][BYTE_W-1];
      end
      SZ_WORD: begin
        nxt_lo = sz_res[1][WORD_W-1:0];
        nxt_c  = sz_c[1];
        nxt_v  = sz_v[1];
        nxt_z  = (sz_res[1][WORD_W-1:0] == '0);
        nxt_n  = sz_res[1][WORD_W-1];
      end
      SZ_DWORD: begin
        nxt_lo = sz_res[2][WORD_W-1:0];
        nxt_hi = sz_res[2][DW_W-1:WORD_W];
        nxt_c  = sz_c[2];
        nxt_v  = sz_v[2];
        nxt_z  = (sz_res[2] == '0);
        nxt_n  = sz_res[2][DW_W-1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_lo_o  <= '0;
      res_hi_o  <= '0;
      flag_c_o  <= 1'b0;
      flag_z_o  <= 1'b0;
      flag_v_o  <= 1'b0;
      flag_n_o  <= 1'b0;
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
    end else begin
      done_o    <= start_i;
      illegal_o <= start_i && (size == SZ_RSVD);
      if (start_i) begin
        res_lo_o <= nxt_lo;
        res_hi_o <= nxt_hi;
        if (size != SZ_RSVD) begin
          flag_c_o <= nxt_c;
          flag_z_o <= nxt_z;
          flag_v_o <= nxt_v;
          flag_n_o <= nxt_n;
        end
      end
    end
  end
endmodule

// File: rtl/ashift_unit_chk.sv
module ashift_unit_chk #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [1:0]        size_i,
  input logic              dir_right_i,
  input logic [WORD_W-1:0] opnd_lo_i,
  input logic [WORD_W-1:0] opnd_hi_i,
  input logic [WORD_W-1:0] res_lo_o,
  input logic [WORD_W-1:0] res_hi_o,
  input logic              flag_c_o,
  input logic              flag_z_o,
  input logic              flag_v_o,
  input logic              flag_n_o,
  input logic              done_o,
  input logic              illegal_o
);
  // R11
  done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> done_o);

  // R11
  done_only_on_start_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(start_i));

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && illegal_o) |-> ($stable(flag_c_o) && $stable(flag_z_o) &&
      $stable(flag_v_o) && $stable(flag_n_o) &&
      res_lo_o == $past(opnd_lo_i) && res_hi_o == $past(opnd_hi_i)));

  // R10
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> done_o);

  // R8
  right_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && !illegal_o && $past(dir_right_i)) |-> !flag_v_o);

  // R7
  dword_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(size_i) == 2'd3) |-> (flag_z_o == ({res_hi_o, res_lo_o} == '0)));

  // R9
  dword_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(size_i) == 2'd3) |-> (flag_n_o == res_hi_o[WORD_W-1]));

  // R2
  hi_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && ($past(size_i) == 2'd0 || $past(size_i) == 2'd1)) |->
      (res_hi_o == $past(opnd_hi_i)));
endmodule

bind ashift_unit ashift_unit_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (.*);

// File: tb/ashift_unit_tb.sv
`timescale 1ns/1ps
module ashift_unit_tb_top;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 5;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [1:0]        size_i = '0;
  logic              dir_right_i = 1'b0;
  logic              cnt_from_reg_i = 1'b1;
  logic [WORD_W-1:0] reg_cnt_i = '0;
  logic [CNT_W-1:0]  imm_cnt_i = '0;
  logic [WORD_W-1:0] opnd_lo_i = '0;
  logic [WORD_W-1:0] opnd_hi_i = '0;
  logic [WORD_W-1:0] res_lo_o, res_hi_o;
  logic flag_c_o, flag_z_o, flag_v_o, flag_n_o, done_o, illegal_o;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ashift_unit #(.WORD_W(WORD_W), .CNT_W(CNT_W)) dut_i (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Step-by-step reference shift
  task automatic model(input int w, input logic [31:0] op, input int cnt, input bit right,
                       output logic [31:0] r, output bit c, output bit v);
    logic [63:0] mask;
    logic [31:0] x;
    mask = (64'd1 << w) - 64'd1;
    x = op & mask[31:0];
    c = 0; v = 0;
    for (int i = 0; i < cnt; i++) begin
      bit s;
      s = x[w-1];
      if (right) begin
        c = x[0];
        x = (x >> 1) | ({31'b0, s} << (w - 1));
      end else begin
        c = x[w-1];
        x = (x << 1) & mask[31:0];
        if (x[w-1] != s) v = 1;
      end
    end
    r = x;
  endtask

  logic [WORD_W-1:0] last_lo, last_hi;

  task automatic run_op(input logic [1:0] sz, input bit right, input bit from_reg,
                        input logic [WORD_W-1:0] rc, input logic [4:0] imm,
                        input logic [WORD_W-1:0] lo, input logic [WORD_W-1:0] hi);
    int w, cnt;
    logic [31:0] op, r;
    bit c, v;
    logic [WORD_W-1:0] elo, ehi;
    w = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
    cnt = from_reg ? int'(rc[4:0]) : (sz == 2'd3 ? int'(imm) : int'(imm[3:0]));
    op = {hi, lo};
    model(w, op, cnt, right, r, c, v);
    elo = (sz == 2'd0) ? {lo[15:8], r[7:0]} : r[15:0];
    ehi = (sz == 2'd3) ? r[31:16] : hi;
    size_i = sz; dir_right_i = right; cnt_from_reg_i = from_reg;
    reg_cnt_i = rc; imm_cnt_i = imm; opnd_lo_i = lo; opnd_hi_i = hi;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk(right ? "R5 result lo" : "R4 result lo", 64'(res_lo_o), 64'(elo));
    chk("R2 result hi", 64'(res_hi_o), 64'(ehi));
    chk(from_reg ? "R6 carry" : "R3 carry (imm count)", 64'(flag_c_o), 64'(c));
    chk("R7 zero", 64'(flag_z_o), 64'(r == 0));
    chk("R8 overflow", 64'(flag_v_o), 64'(v));
    chk("R9 negative", 64'(flag_n_o), 64'(r[w-1]));
    chk("R11 done", 64'(done_o), 64'd1);
    chk("R10 illegal low", 64'(illegal_o), 64'd0);
  endtask

  function automatic logic [31:0] pat(input int k);
    case (k)
      0: pat = 32'h0000_0000;
      1: pat = 32'h8000_0000;
      2: pat = 32'h7FFF_FFFF;
      3: pat = 32'hFFFF_FFFF;
      4: pat = 32'h0000_8000;
      5: pat = 32'h4000_0001;
      default: pat = (32'(k) * 32'h9E37_79B9) ^ (32'(k) << 13);
    endcase
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 res_lo", 64'(res_lo_o), 0);
    chk("R1 res_hi", 64'(res_hi_o), 0);
    chk("R1 flags", 64'({flag_c_o, flag_z_o, flag_v_o, flag_n_o}), 0);
    chk("R1 done", 64'(done_o), 0);
    chk("R1 illegal", 64'(illegal_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // Byte exhaustive, register count with junk upper bits (R3)
    for (int op = 0; op < 256; op++)
      for (int cnt = 0; cnt < 32; cnt++)
        for (int d = 0; d < 2; d++)
          run_op(2'd0, d[0], 1'b1, 16'hA5E0 | 16'(cnt), 5'd0,
                 {8'(op) ^ 8'h5A, 8'(op)}, 16'h3C00 + 16'(op));

    // Word and doubleword pattern sweeps
    for (int k = 0; k < 64; k++)
      for (int cnt = 0; cnt < 32; cnt++)
        for (int d = 0; d < 2; d++) begin
          logic [31:0] p;
          p = pat(k);
          run_op(2'd1, d[0], 1'b1, 16'hFFE0 | 16'(cnt), 5'd0, p[15:0], p[31:16]);
          run_op(2'd3, d[0], 1'b1, 16'h7F40 | 16'(cnt), 5'd0, p[15:0], p[31:16]);
        end

    // R3 immediate count widths
    for (int k = 0; k < 16; k++)
      for (int imm = 0; imm < 32; imm++)
        for (int d = 0; d < 2; d++) begin
          logic [31:0] p;
          p = pat(k);
          run_op(2'd0, d[0], 1'b0, 16'h001F, 5'(imm), p[15:0], p[31:16]);
          run_op(2'd1, d[0], 1'b0, 16'h001F, 5'(imm), p[15:0], p[31:16]);
          run_op(2'd3, d[0], 1'b0, 16'h001F, 5'(imm), p[15:0], p[31:16]);
        end

    // R11 hold with no start: byte 0x80 << 1 -> 0x00, C=1 Z=1 V=1 N=0
    run_op(2'd0, 1'b0, 1'b1, 16'd1, 5'd0, 16'h1280, 16'hBEEF);
    @(negedge clk);
    chk("R11 done drops", 64'(done_o), 0);
    chk("R11 hold lo", 64'(res_lo_o), 64'h1200);
    chk("R11 hold hi", 64'(res_hi_o), 64'hBEEF);
    chk("R11 hold flags", 64'({flag_c_o, flag_z_o, flag_v_o, flag_n_o}), 64'b1110);

    // R10 reserved size
    size_i = 2'd2; dir_right_i = 1'b1; cnt_from_reg_i = 1'b1; reg_cnt_i = 16'd3;
    opnd_lo_i = 16'h1234; opnd_hi_i = 16'h5678; start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk("R10 illegal", 64'(illegal_o), 1);
    chk("R10 done", 64'(done_o), 1);
    chk("R10 lo unchanged", 64'(res_lo_o), 64'h1234);
    chk("R10 hi unchanged", 64'(res_hi_o), 64'h5678);
    chk("R10 flags held", 64'({flag_c_o, flag_z_o, flag_v_o, flag_n_o}), 64'b1110);
    @(negedge clk);
    chk("R10 illegal clears", 64'(illegal_o), 0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule